// File: doc/BRIEF.md
# Storage-card task-file status and interrupt logic

This block keeps the device-side status state of a disk-style storage card register file. It assembles the status byte the host reads, holds the interrupt request to the host, gates the DMA request so that it can only be active while a command owns the transfer, and keeps the sector and cylinder registers plus the drive/head register from which the 28-bit logical block address is formed.

The host side is a plain register port: a read strobe and a write strobe that share one offset address, with registered read data. The device side drives strobes for ready, command completion (with error and write-fault flags), corrected-data events, a data-request level and a raw DMA request. A command write from the host locks the register file until the device completes the command or reports ready.

Top module: `ata_taskfile_status`

## Requirements
- R1: The status byte is, MSB first, BUSY, RDY, DWF, DSC, DRQ, CORR, IDX, ERR; IDX (bit 1) always reads 0; offsets 0x7 and 0xE return the same byte.
- R2: A read at offset 0x7 clears a pending interrupt; a read at offset 0xE leaves it unchanged.
- R3: The interrupt sets on `dev_done` and stays set until a read at offset 0x7 or a reset; when both occur in one cycle it ends set.
- R4: While BUSY is 1 a status read at 0x7 or 0xE returns 0x80.
- R5: Synchronous reset sets BUSY to 1, clears every other status bit, the interrupt, the DMA request, the command strobe and all task-file registers.
- R6: `dev_ready` clears BUSY and sets RDY (bit 6) and DSC (bit 4); RDY stays 0 after reset until then.
- R7: `dma_req_out` is `dma_req_in` registered one cycle, forced low unless BUSY or DRQ was 1 in the cycle the request was sampled.
- R8: `dev_corr` sets CORR (bit 2) without changing BUSY or DRQ; DRQ (bit 3) follows `dev_drq` one cycle late.
- R9: A write at offset 0x7 while BUSY is 0 pulses `cmd_valid` for one cycle with `cmd_code` equal to the written byte, sets BUSY and clears ERR, DWF and CORR; while BUSY is 1 it is ignored.
- R10: Writes at offsets 0x3 to 0x6 update the sector, cylinder-low, cylinder-high and drive/head registers and read back at the same offsets, but are ignored while BUSY is 1.
- R11: `lba_addr` is {drive/head[3:0], cylinder-high, cylinder-low, sector}, and `lba_mode` is drive/head bit 6.
- R12: `dev_done` clears BUSY and loads ERR (bit 0) from `dev_err` and DWF (bit 5) from `dev_fault`; later strobes in priority order are command accept, done, ready, corrected.
- R13: `host_rdata` updates one cycle after a read strobe and holds otherwise; offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| host_irq | output | 1 | Pending interrupt to host |
| dev_ready | input | 1 | Device can accept commands |
| dev_done | input | 1 | Command completion strobe |
| dev_err | input | 1 | Completion ended in error |
| dev_fault | input | 1 | Completion ended in write fault |
| dev_corr | input | 1 | Corrected data error strobe |
| dev_drq | input | 1 | Data request level |
| dma_req_in | input | 1 | Raw DMA request from transfer engine |
| dma_req_out | output | 1 | Gated, registered DMA request |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_code | output | 8 | Accepted command byte |
| lba_addr | output | 28 | Logical block address |
| lba_mode | output | 1 | Address mode bit of drive/head |

## Verification
The bench aims at the difference between the two status offsets: a design that cleared the interrupt on the alternate read would drop host_irq after an 0xE read, and one that let the read win over a same-cycle completion would lose an interrupt. It checks the 0x80 mask under BUSY, where a design without it would leak stale ERR or DRQ bits, and the lockout, where a design without it would change the LBA or issue a second command mid-operation. DMA requests are driven while idle, busy and in DRQ phases, so an ungated design would raise dma_req_out with neither bit set, and corrected-error strobes arrive during data phases, where a design that cleared BUSY or DRQ would end the transfer.

// File: rtl/ata_status_pkg.sv
package ata_status_pkg;
  localparam int TF_AW = 4;
  localparam int TF_DW = 8;

  localparam logic [TF_AW-1:0] OFS_SECT   = 4'h3;
  localparam logic [TF_AW-1:0] OFS_CYL_LO = 4'h4;
  localparam logic [TF_AW-1:0] OFS_CYL_HI = 4'h5;
  localparam logic [TF_AW-1:0] OFS_DRVHD  = 4'h6;
  localparam logic [TF_AW-1:0] OFS_STAT   = 4'h7;
  localparam logic [TF_AW-1:0] OFS_ALT    = 4'hE;

  localparam int NUM_TF_REGS = 4;

  typedef struct packed {
    logic busy;
    logic rdy;
    logic dwf;
    logic dsc;
    logic drq;
    logic corr;
    logic err;
  } stat_flags_t;

  function automatic logic [TF_DW-1:0] pack_status(input stat_flags_t f);
    logic [TF_DW-1:0] b;
    if (f.busy) begin
      b = 8'h80;
    end else begin
      b = {1'b0, f.rdy, f.dwf, f.dsc, f.drq, f.corr, 1'b0, f.err};
    end
    return b;
  endfunction
endpackage

// File: rtl/ata_status_flags.sv
module ata_status_flags
  import ata_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_accept,
  input  logic        dev_ready,
  input  logic        dev_done,
  input  logic        dev_err,
  input  logic        dev_fault,
  input  logic        dev_corr,
  input  logic        dev_drq,
  input  logic        stat_read,
  output stat_flags_t flags,
  output logic        irq
);
  stat_flags_t f_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q      <= '0;
      f_q.busy <= 1'b1;
    end else begin
      if (cmd_accept) begin
        f_q.busy <= 1'b1;
        f_q.err  <= 1'b0;
        f_q.dwf  <= 1'b0;
        f_q.corr <= 1'b0;
      end
      if (dev_done) begin
        f_q.busy <= 1'b0;
        f_q.err  <= dev_err;
        f_q.dwf  <= dev_fault;
      end
      if (dev_ready) begin
        f_q.busy <= 1'b0;
        f_q.rdy  <= 1'b1;
        f_q.dsc  <= 1'b1;
      end
      if (dev_corr) begin
        f_q.corr <= 1'b1;
      end
      f_q.drq <= dev_drq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (dev_done) begin
      irq <= 1'b1;
    end else if (stat_read) begin
      irq <= 1'b0;
    end
  end

  assign flags = f_q;
endmodule

// File: rtl/ata_taskfile_bank.sv
module ata_taskfile_bank
  import ata_status_pkg::*;
#(
  parameter int AW    = TF_AW,
  parameter int DW    = TF_DW,
  parameter int NREGS = NUM_TF_REGS,
  parameter logic [AW-1:0] BASE = OFS_SECT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                locked,
  output logic [NREGS*DW-1:0] regs_flat
);
  genvar gi;
  generate
    for (gi = 0; gi < NREGS; gi++) begin : g_reg
      localparam logic [AW-1:0] MY_OFS = BASE + AW'(gi);
      logic [DW-1:0] r_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          r_q <= '0;
        end else if (wr_en && !locked && (addr == MY_OFS)) begin
          r_q <= wdata;
        end
      end
      assign regs_flat[gi*DW +: DW] = r_q;
    end
  endgenerate
endmodule

// File: rtl/ata_host_port.sv
module ata_host_port
  import ata_status_pkg::*;
#(
  parameter int AW    = TF_AW,
  parameter int DW    = TF_DW,
  parameter int NREGS = NUM_TF_REGS,
  parameter logic [AW-1:0] BASE = OFS_SECT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic                cmd_accept,
  input  logic [DW-1:0]       wdata,
  input  stat_flags_t         flags,
  input  logic [NREGS*DW-1:0] regs_flat,
  input  logic                dma_in,
  output logic [DW-1:0]       rdata,
  output logic                dma_out,
  output logic                cmd_valid,
  output logic [DW-1:0]       cmd_code
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_STAT || addr == OFS_ALT) begin
      rd_mux = pack_status(flags);
    end
    for (int i = 0; i < NREGS; i++) begin
      if (addr == BASE + AW'(i)) begin
        rd_mux = regs_flat[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_out   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      dma_out   <= dma_in && (flags.busy || flags.drq);
      cmd_valid <= cmd_accept;
      if (cmd_accept) begin
        cmd_code <= wdata;
      end
    end
  end
endmodule

// File: rtl/ata_taskfile_status.sv
module ata_taskfile_status
  import ata_status_pkg::*;
#(
  parameter int AW = TF_AW,
  parameter int DW = TF_DW,
  localparam int HEAD_W = 4,
  localparam int LBA_W  = HEAD_W + 3*DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_irq,
  input  logic              dev_ready,
  input  logic              dev_done,
  input  logic              dev_err,
  input  logic              dev_fault,
  input  logic              dev_corr,
  input  logic              dev_drq,
  input  logic              dma_req_in,
  output logic              dma_req_out,
  output logic              cmd_valid,
  output logic [DW-1:0]     cmd_code,
  output logic [LBA_W-1:0]  lba_addr,
  output logic              lba_mode
);
  localparam int NREGS = NUM_TF_REGS;

  stat_flags_t           flags;
  logic [NREGS*DW-1:0]   regs_flat;
  logic                  cmd_accept;
  logic                  stat_read;
  logic                  st_busy;
  logic                  st_drq;
  logic [DW-1:0]         r_sect, r_cyl_lo, r_cyl_hi, r_drvhd;

  assign st_busy    = flags.busy;
  assign st_drq     = flags.drq;
  assign cmd_accept = host_wr && (host_addr == OFS_STAT) && !flags.busy;
  assign stat_read  = host_rd && (host_addr == OFS_STAT);

  ata_status_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .cmd_accept(cmd_accept),
    .dev_ready (dev_ready),
    .dev_done  (dev_done),
    .dev_err   (dev_err),
    .dev_fault (dev_fault),
    .dev_corr  (dev_corr),
    .dev_drq   (dev_drq),
    .stat_read (stat_read),
    .flags     (flags),
    .irq       (host_irq)
  );

  ata_taskfile_bank #(.AW(AW), .DW(DW), .NREGS(NREGS), .BASE(OFS_SECT)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (host_wr),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .locked   (flags.busy),
    .regs_flat(regs_flat)
  );

  ata_host_port #(.AW(AW), .DW(DW), .NREGS(NREGS), .BASE(OFS_SECT)) u_port (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (host_rd),
    .addr      (host_addr),
    .cmd_accept(cmd_accept),
    .wdata     (host_wdata),
    .flags     (flags),
    .regs_flat (regs_flat),
    .dma_in    (dma_req_in),
    .rdata     (host_rdata),
    .dma_out   (dma_req_out),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );

  assign r_sect   = regs_flat[0*DW +: DW];
  assign r_cyl_lo = regs_flat[1*DW +: DW];
  assign r_cyl_hi = regs_flat[2*DW +: DW];
  assign r_drvhd  = regs_flat[3*DW +: DW];

  assign lba_addr = {r_drvhd[HEAD_W-1:0], r_cyl_hi, r_cyl_lo, r_sect};
  assign lba_mode = r_drvhd[6];
endmodule

// File: rtl/ata_taskfile_status_chk.sv
module ata_taskfile_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_rd,
  input logic        host_wr,
  input logic [3:0]  host_addr,
  input logic [7:0]  host_rdata,
  input logic        host_irq,
  input logic        dev_done,
  input logic        dma_req_in,
  input logic        dma_req_out,
  input logic        cmd_valid,
  input logic [27:0] lba_addr,
  input logic        busy,
  input logic        drq
);
  a_r2_alt_keeps_irq: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 4'hE && host_irq) |=> host_irq);

  a_r2_stat_clears_irq: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 4'h7 && !dev_done) |=> !host_irq);

  a_r3_done_sets_irq: assert property (@(posedge clk) disable iff (rst)
    dev_done |=> host_irq);

  a_r4_busy_mask: assert property (@(posedge clk) disable iff (rst)
    (host_rd && (host_addr == 4'h7 || host_addr == 4'hE) && busy) |=> host_rdata == 8'h80);

  a_r1_idx_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 4'h7) |=> !host_rdata[1]);

  a_r5_reset_state: assert property (@(posedge clk)
    rst |=> (busy && !host_irq && !dma_req_out && !cmd_valid));

  a_r7_dma_gate: assert property (@(posedge clk) disable iff (rst)
    dma_req_out |-> ($past(dma_req_in) && $past(busy || drq)));

  a_r9_cmd_single: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  a_r10_lockout: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr) |=> $stable(lba_addr));
endmodule

bind ata_taskfile_status ata_taskfile_status_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .host_irq   (host_irq),
  .dev_done   (dev_done),
  .dma_req_in (dma_req_in),
  .dma_req_out(dma_req_out),
  .cmd_valid  (cmd_valid),
  .lba_addr   (lba_addr),
  .busy       (st_busy),
  .drq        (st_drq)
);

// File: tb/ata_taskfile_status_test.sv
module ata_taskfile_status_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic host_rd, host_wr;
  logic [3:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic host_irq;
  logic dev_ready, dev_done, dev_err, dev_fault, dev_corr, dev_drq;
  logic dma_req_in, dma_req_out, cmd_valid;
  logic [7:0] cmd_code;
  logic [27:0] lba_addr;
  logic lba_mode;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // reference model state
  bit m_busy, m_rdy, m_dwf, m_dsc, m_drq, m_corr, m_err, m_irq, m_dma, m_cv;
  bit [7:0] m_rdata, m_code;
  bit [7:0] m_tf [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile_status uut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .dev_ready(dev_ready), .dev_done(dev_done),
    .dev_err(dev_err), .dev_fault(dev_fault), .dev_corr(dev_corr),
    .dev_drq(dev_drq), .dma_req_in(dma_req_in), .dma_req_out(dma_req_out),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .lba_addr(lba_addr),
    .lba_mode(lba_mode)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit [7:0] exp_status();
    if (m_busy) return 8'h80;
    return {1'b0, m_rdy, m_dwf, m_dsc, m_drq, m_corr, 1'b0, m_err};
  endfunction

  function automatic bit [7:0] exp_read(input bit [3:0] a);
    if (a == 4'h7 || a == 4'hE) return exp_status();
    if (a >= 4'h3 && a <= 4'h6) return m_tf[a - 4'h3];
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_busy = 1; m_rdy = 0; m_dwf = 0; m_dsc = 0; m_drq = 0; m_corr = 0; m_err = 0;
    m_irq = 0; m_dma = 0; m_cv = 0; m_rdata = 0; m_code = 0;
    for (int i = 0; i < 4; i++) m_tf[i] = 0;
  endtask

  task automatic idle_inputs();
    host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    dev_ready = 0; dev_done = 0; dev_err = 0; dev_fault = 0; dev_corr = 0;
    dma_req_in = 0;
  endtask

  // one clock: inputs already driven; update model, wait, compare
  task automatic step();
    bit rd, wr, acc, did_rd;
    bit [3:0] a;
    bit [7:0] rd_val;
    bit n_busy;
    rd = host_rd; wr = host_wr; a = host_addr;
    did_rd = rd;
    rd_val = exp_read(a);
    acc = wr && a == 4'h7 && !m_busy;
    m_dma = dma_req_in && (m_busy || m_drq);
    m_cv = acc;
    if (acc) m_code = host_wdata;
    if (wr && !m_busy && a >= 4'h3 && a <= 4'h6) m_tf[a - 4'h3] = host_wdata;
    n_busy = m_busy;
    if (acc) begin n_busy = 1; m_err = 0; m_dwf = 0; m_corr = 0; end
    if (dev_done) begin n_busy = 0; m_err = dev_err; m_dwf = dev_fault; end
    if (dev_ready) begin n_busy = 0; m_rdy = 1; m_dsc = 1; end
    if (dev_corr) m_corr = 1;
    m_drq = dev_drq;
    m_busy = n_busy;
    if (dev_done) m_irq = 1;
    else if (rd && a == 4'h7) m_irq = 0;
    if (rd) m_rdata = rd_val;
    @(negedge clk);
    idle_inputs();
    if (did_rd) chk("R13 R1 R4 read data", host_rdata, m_rdata);
    chk("R2 R3 irq", host_irq, m_irq);
    chk("R7 dma gate", dma_req_out, m_dma);
    chk("R9 cmd_valid", cmd_valid, m_cv);
    if (m_cv) chk("R9 cmd_code", cmd_code, m_code);
    chk("R11 lba_addr", lba_addr, {m_tf[3][3:0], m_tf[2], m_tf[1], m_tf[0]});
    chk("R11 lba_mode", lba_mode, m_tf[3][6]);
  endtask

  task automatic rd(input bit [3:0] a);
    host_rd = 1; host_addr = a; step();
  endtask

  task automatic wr(input bit [3:0] a, input bit [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2718);
    idle_inputs();
    dev_drq = 0;
    rst = 1;
    model_reset();
    repeat (5) @(negedge clk);
    // R5: reset state
    chk("R5 reset irq", host_irq, 0);
    chk("R5 reset dma", dma_req_out, 0);
    chk("R5 reset cmd_valid", cmd_valid, 0);
    chk("R5 reset lba", lba_addr, 0);
    rst = 0;
    // R4 R5: busy after reset reads 0x80, writes locked
    rd(4'h7);
    chk("R5 status after reset", host_rdata, 8'h80);
    wr(4'h6, 8'h5F);
    rd(4'h6);
    chk("R10 locked drvhd", host_rdata, 8'h00);
    // R7: dma passes while busy
    dma_req_in = 1; step();
    chk("R7 dma while busy", dma_req_out, 1);
    // R6: ready
    dev_ready = 1; step();
    rd(4'hE);
    chk("R6 rdy dsc", host_rdata, 8'h50);
    // R7: dma blocked when idle
    dma_req_in = 1; step();
    chk("R7 dma blocked idle", dma_req_out, 0);
    // R10 R11: task file writes and lba
    wr(4'h3, 8'h12); wr(4'h4, 8'h34); wr(4'h5, 8'h56); wr(4'h6, 8'hE7);
    chk("R11 lba value", lba_addr, 28'h7563412);
    chk("R11 lba mode", lba_mode, 1);
    rd(4'h5);
    chk("R10 readback", host_rdata, 8'h56);
    rd(4'h9);
    chk("R13 unmapped", host_rdata, 8'h00);
    // R9: command accept then lockout
    wr(4'h7, 8'h20);
    chk("R9 cmd pulse", cmd_valid, 1);
    chk("R9 cmd code", cmd_code, 8'h20);
    wr(4'h7, 8'h30);
    chk("R9 second cmd ignored", cmd_valid, 0);
    wr(4'h3, 8'hAA);
    chk("R10 lockout lba", lba_addr, 28'h7563412);
    // R8: drq and corr during transfer
    dev_drq = 1; step();
    dev_corr = 1; step();
    dev_done = 1; step();
    rd(4'h7);
    chk("R8 corr drq kept", host_rdata, 8'h5C);
    chk("R2 status read clears irq", host_irq, 0);
    // R12: completion with error and fault
    dev_drq = 0;
    wr(4'h7, 8'h30);
    dev_done = 1; dev_err = 1; dev_fault = 1; step();
    rd(4'hE);
    chk("R12 err dwf", host_rdata, 8'h71);
    chk("R2 alt keeps irq", host_irq, 1);
    // R3: set wins over status-read clear
    dev_done = 1; host_rd = 1; host_addr = 4'h7; step();
    chk("R3 set priority", host_irq, 1);
    rd(4'h7);
    chk("R3 cleared by read", host_irq, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit [2:0] sel;
      sel = 3'($urandom_range(0, 7));
      host_addr = (sel == 0) ? 4'h0 : (sel == 1) ? 4'hE : (sel == 2) ? 4'h9 : 4'(sel + 1);
      host_rd = ($urandom_range(0, 9) < 3);
      host_wr = ($urandom_range(0, 9) < 3);
      host_wdata = 8'($urandom);
      dev_done = ($urandom_range(0, 19) == 0);
      dev_ready = ($urandom_range(0, 39) == 0);
      dev_corr = ($urandom_range(0, 19) == 0);
      dev_err = 1'($urandom);
      dev_fault = 1'($urandom);
      dma_req_in = 1'($urandom);
      if ($urandom_range(0, 7) == 0) dev_drq = ~dev_drq;
      step();
    end
    // reset mid-run
    rst = 1; model_reset(); @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R5 reset mid-run irq", host_irq, 0);
    chk("R5 reset mid-run lba", lba_addr, 0);
    rd(4'h7);
    chk("R5 R4 busy after reset", host_rdata, 8'h80);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule